// File: doc/BRIEF.md
# I2C Slave Front-End with Dual Type-Identifier Select

This block sits between the two wires of a serial bus and the transaction controller of a presence-detect memory slave. It brings the clock and data lines into the system clock domain and finds START and STOP conditions. It shifts bytes in most-significant bit first on each rising clock-line edge and pulls the data line low for the ninth-bit acknowledge. The first byte after each START is decoded as a select code. That code can address either the memory array or a one-shot protection register, and three strap inputs qualify it.

Bytes that follow an accepted write select are handed to the controller, which can refuse any one of them. After an accepted read select, the block takes bytes from the controller and shifts them onto the bus. It watches the master's acknowledge after each byte and drops back to standby on a NoAck. While the controller reports an internal write cycle, the block is blind to the bus. Once the controller reports that protection has been set, the register identifier is no longer answered. The system clock must run at least eight times faster than the bus clock.

Top module: `spd_i2c_front`

## Requirements
- R1: A falling data-line edge while the clock line is high gives a one-cycle `bus_start` pulse. A rising data-line edge while the clock line is high gives a one-cycle `bus_stop` pulse. After reset the block drives nothing and issues no strobes.
- R2: A select byte has the type identifier in bits 7:4, the chip address in bits 3:1 and the direction in bit 0 (1 = read). Identifier 1010 with bits 3:1 equal to `strap_addr` is acknowledged by pulling the data line low during the ninth clock. It also gives a `sel_valid` pulse with `sel_target` = 0.
- R3: Identifier 0110 with a matching chip address is acknowledged while `prot_locked` is low, with `sel_target` = 1.
- R4: While `prot_locked` is high, identifier 0110 is not acknowledged and gives no `sel_valid`. Identifier 1010 is still acknowledged.
- R5: Any other identifier, or a chip address that differs from `strap_addr`, gets no acknowledge. The bytes that follow it give no `byte_valid` and no acknowledge until the next START.
- R6: After an accepted write select, each following byte appears on `byte_data` with a `byte_valid` pulse, assembled MSB first, and is acknowledged.
- R7: A byte that completes while `wr_nack` is high still gives `byte_valid`, but it is not acknowledged.
- R8: After an accepted read select, the block shifts out `rd_data` MSB first, pulsing `rd_take` as it loads each byte, and releases the line in the ninth clock. If the master acknowledges, the next byte follows. After a NoAck the block stays released until the next START.
- R9: While `wr_busy` is high, the bus is ignored: no START or STOP pulse, no select decode, and no acknowledge.
- R10: A START in the middle of a byte discards the partial byte and restarts select-code reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line as seen on the wire, asynchronous |
| strap_addr | input | 3 | Chip address straps compared with select bits 3:1 |
| prot_locked | input | 1 | Protection has been set; stop answering the register identifier |
| wr_busy | input | 1 | Internal write cycle in progress; ignore the bus |
| wr_nack | input | 1 | Refuse (do not acknowledge) the write byte completing now |
| rd_data | input | 8 | Next byte to transmit, sampled when `rd_take` is issued |
| sda_pull | output | 1 | Open-drain pull-down enable for the data line |
| bus_start | output | 1 | One-cycle START / repeated-START strobe |
| bus_stop | output | 1 | One-cycle STOP strobe |
| sel_valid | output | 1 | One-cycle strobe for an accepted select code |
| sel_target | output | 1 | Selected target: 0 memory array, 1 protection register |
| sel_read | output | 1 | Direction of the accepted select: 1 read |
| byte_valid | output | 1 | One-cycle strobe for a received write byte |
| byte_data | output | 8 | Last received write byte |
| rd_take | output | 1 | One-cycle strobe: `rd_data` loaded, controller may advance |
| rd_done | output | 1 | One-cycle strobe at the master's ninth-bit sample |
| rd_master_ack | output | 1 | Master acknowledged the last transmitted byte |

## Verification
Most wrong internal states show at the bus within one byte time. A bad bit count or a wrong select decode makes the ninth-clock acknowledge appear or vanish on the very next select byte. A wrong shift direction corrupts the first byte the master reads or the `byte_data` it writes. A state machine that misses a START, a NoAck or the busy input keeps driving or answering the line. That shows on the next transfer, as a stray acknowledge or as data bits pulled low when the master expects a released line.

// File: rtl/spd_i2c_pkg.sv
package spd_i2c_pkg;

    localparam int BYTE_W = 8;
    localparam int ID_W   = 4;
    localparam int CE_W   = 3;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL,
        ST_SEL_ACK,
        ST_WRX,
        ST_WR_ACK,
        ST_RDX,
        ST_RD_ACK
    } fe_state_e;

    typedef enum logic {
        TGT_ARRAY = 1'b0,
        TGT_PROT  = 1'b1
    } target_e;

    typedef struct packed {
        logic    hit;
        target_e target;
        logic    read;
    } sel_dec_t;

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } line_ev_t;

    function automatic sel_dec_t decode_select(
        input logic [BYTE_W-1:0] code,
        input logic [CE_W-1:0]   strap,
        input logic              locked,
        input logic [ID_W-1:0]   array_id,
        input logic [ID_W-1:0]   prot_id
    );
        sel_dec_t        d;
        logic [ID_W-1:0] id;
        logic            addr_ok;
        id       = code[BYTE_W-1 -: ID_W];
        addr_ok  = (code[CE_W:1] == strap);
        d.read   = code[0];
        d.target = (id == prot_id) ? TGT_PROT : TGT_ARRAY;
        d.hit    = addr_ok && ((id == array_id) || ((id == prot_id) && !locked));
        return d;
    endfunction

endpackage

// File: rtl/spd_i2c_linesync.sv
module spd_i2c_linesync
    import spd_i2c_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     raw,
    output line_ev_t ev
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
            prev  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], raw};
            prev  <= chain[STAGES-1];
        end
    end

    always_comb begin
        ev.level = chain[STAGES-1];
        ev.rise  = chain[STAGES-1] & ~prev;
        ev.fall  = ~chain[STAGES-1] & prev;
    end
endmodule

// File: rtl/spd_i2c_cond.sv
module spd_i2c_cond
    import spd_i2c_pkg::*;
(
    input  line_ev_t scl,
    input  line_ev_t sda,
    output logic     start_det,
    output logic     stop_det
);
    always_comb begin
        start_det = sda.fall & scl.level & ~scl.rise;
        stop_det  = sda.rise & scl.level & ~scl.rise;
    end
endmodule

// File: rtl/spd_i2c_seldec.sv
module spd_i2c_seldec
    import spd_i2c_pkg::*;
#(
    parameter logic [ID_W-1:0] ARRAY_ID = 4'b1010,
    parameter logic [ID_W-1:0] PROT_ID  = 4'b0110
) (
    input  logic [BYTE_W-1:0] code,
    input  logic [CE_W-1:0]   strap,
    input  logic              locked,
    output sel_dec_t          dec
);
    always_comb dec = decode_select(code, strap, locked, ARRAY_ID, PROT_ID);
endmodule

// File: rtl/spd_i2c_front.sv
module spd_i2c_front
    import spd_i2c_pkg::*;
#(
    parameter int               SYNC_STAGES = 2,
    parameter logic [ID_W-1:0]  ARRAY_ID    = 4'b1010,
    parameter logic [ID_W-1:0]  PROT_ID     = 4'b0110
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [CE_W-1:0]   strap_addr,
    input  logic              prot_locked,
    input  logic              wr_busy,
    input  logic              wr_nack,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_pull,
    output logic              bus_start,
    output logic              bus_stop,
    output logic              sel_valid,
    output logic              sel_target,
    output logic              sel_read,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_data,
    output logic              rd_take,
    output logic              rd_done,
    output logic              rd_master_ack
);
    localparam int NLINES = 2;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_TX  = CNT_W'(BYTE_W - 1);

    logic [NLINES-1:0] raw_lines;
    line_ev_t          line_ev [NLINES];
    line_ev_t          scl_ev, sda_ev;

    assign raw_lines = {sda_in, scl_in};

    for (genvar g = 0; g < NLINES; g++) begin : g_sync
        spd_i2c_linesync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .rst (rst),
            .raw (raw_lines[g]),
            .ev  (line_ev[g])
        );
    end

    assign scl_ev = line_ev[0];
    assign sda_ev = line_ev[1];

    logic start_det, stop_det;

    spd_i2c_cond u_cond (
        .scl       (scl_ev),
        .sda       (sda_ev),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    fe_state_e         state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    sel_dec_t          dec;

    spd_i2c_seldec #(.ARRAY_ID(ARRAY_ID), .PROT_ID(PROT_ID)) u_dec (
        .code   (shreg),
        .strap  (strap_addr),
        .locked (prot_locked),
        .dec    (dec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= ST_IDLE;
            bit_cnt       <= '0;
            shreg         <= '0;
            sda_pull      <= 1'b0;
            bus_start     <= 1'b0;
            bus_stop      <= 1'b0;
            sel_valid     <= 1'b0;
            sel_target    <= 1'b0;
            sel_read      <= 1'b0;
            byte_valid    <= 1'b0;
            byte_data     <= '0;
            rd_take       <= 1'b0;
            rd_done       <= 1'b0;
            rd_master_ack <= 1'b0;
        end else begin
            bus_start  <= start_det & ~wr_busy;
            bus_stop   <= stop_det & ~wr_busy;
            sel_valid  <= 1'b0;
            byte_valid <= 1'b0;
            rd_take    <= 1'b0;
            rd_done    <= 1'b0;

            if (wr_busy) begin
                state    <= ST_IDLE;
                sda_pull <= 1'b0;
            end else if (start_det) begin
                state    <= ST_SEL;
                bit_cnt  <= '0;
                sda_pull <= 1'b0;
            end else if (stop_det) begin
                state    <= ST_IDLE;
                sda_pull <= 1'b0;
            end else begin
                unique case (state)
                    ST_IDLE: sda_pull <= 1'b0;

                    ST_SEL: begin
                        if (scl_ev.rise && bit_cnt != FULL_CNT) begin
                            shreg   <= {shreg[BYTE_W-2:0], sda_ev.level};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_ev.fall && bit_cnt == FULL_CNT) begin
                            if (dec.hit) begin
                                state      <= ST_SEL_ACK;
                                sda_pull   <= 1'b1;
                                sel_valid  <= 1'b1;
                                sel_target <= dec.target;
                                sel_read   <= dec.read;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end

                    ST_SEL_ACK: begin
                        if (scl_ev.fall) begin
                            bit_cnt <= '0;
                            if (sel_read) begin
                                state    <= ST_RDX;
                                shreg    <= rd_data;
                                sda_pull <= ~rd_data[BYTE_W-1];
                                rd_take  <= 1'b1;
                            end else begin
                                state    <= ST_WRX;
                                sda_pull <= 1'b0;
                            end
                        end
                    end

                    ST_WRX: begin
                        if (scl_ev.rise && bit_cnt != FULL_CNT) begin
                            shreg   <= {shreg[BYTE_W-2:0], sda_ev.level};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_ev.fall && bit_cnt == FULL_CNT) begin
                            state      <= ST_WR_ACK;
                            byte_valid <= 1'b1;
                            byte_data  <= shreg;
                            sda_pull   <= ~wr_nack;
                        end
                    end

                    ST_WR_ACK: begin
                        if (scl_ev.fall) begin
                            state    <= ST_WRX;
                            bit_cnt  <= '0;
                            sda_pull <= 1'b0;
                        end
                    end

                    ST_RDX: begin
                        if (scl_ev.fall) begin
                            if (bit_cnt == LAST_TX) begin
                                state    <= ST_RD_ACK;
                                sda_pull <= 1'b0;
                            end else begin
                                shreg    <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_pull <= ~shreg[BYTE_W-2];
                                bit_cnt  <= bit_cnt + 1'b1;
                            end
                        end
                    end

                    ST_RD_ACK: begin
                        if (scl_ev.rise && bit_cnt != FULL_CNT) begin
                            rd_done       <= 1'b1;
                            rd_master_ack <= ~sda_ev.level;
                            if (sda_ev.level) state <= ST_IDLE;
                            else              bit_cnt <= FULL_CNT;
                        end else if (scl_ev.fall && bit_cnt == FULL_CNT) begin
                            state    <= ST_RDX;
                            bit_cnt  <= '0;
                            shreg    <= rd_data;
                            sda_pull <= ~rd_data[BYTE_W-1];
                            rd_take  <= 1'b1;
                        end
                    end

                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/spd_i2c_front_chk.sv
module spd_i2c_front_chk (
    input logic clk,
    input logic rst,
    input logic prot_locked,
    input logic wr_busy,
    input logic wr_nack,
    input logic sda_pull,
    input logic bus_stop,
    input logic sel_valid,
    input logic sel_target,
    input logic byte_valid,
    input logic rd_take,
    input logic rd_done,
    input logic rd_master_ack
);
    assert_busy_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        wr_busy |=> !sda_pull);

    assert_lock_blocks_reg_R4: assert property (@(posedge clk) disable iff (rst)
        (sel_valid && sel_target) |-> !$past(prot_locked));

    assert_stop_releases_R1: assert property (@(posedge clk) disable iff (rst)
        bus_stop |-> !sda_pull);

    assert_noack_standby_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_done && !rd_master_ack) |=> !sda_pull);

    assert_strobes_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sel_valid, byte_valid, rd_take, rd_done}));

    assert_refused_byte_R7: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && $past(wr_nack)) |-> !sda_pull);
endmodule

bind spd_i2c_front spd_i2c_front_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .prot_locked   (prot_locked),
    .wr_busy       (wr_busy),
    .wr_nack       (wr_nack),
    .sda_pull      (sda_pull),
    .bus_stop      (bus_stop),
    .sel_valid     (sel_valid),
    .sel_target    (sel_target),
    .byte_valid    (byte_valid),
    .rd_take       (rd_take),
    .rd_done       (rd_done),
    .rd_master_ack (rd_master_ack)
);

// File: tb/spd_i2c_front_test.sv
module spd_i2c_front_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_line;
    logic [2:0] strap_addr = 3'd0;
    logic       prot_locked = 1'b0;
    logic       wr_busy = 1'b0;
    logic       wr_nack = 1'b0;
    logic [7:0] rd_data;
    logic       sda_pull, bus_start, bus_stop, sel_valid, sel_target, sel_read;
    logic       byte_valid, rd_take, rd_done, rd_master_ack;
    logic [7:0] byte_data;

    int n_checks = 0;
    int n_fail = 0;
    int start_cnt = 0, stop_cnt = 0, sel_cnt = 0, byte_cnt = 0, take_cnt = 0, done_cnt = 0;
    int rd_ptr = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    assign sda_line = m_sda & ~sda_pull;

    function automatic logic [7:0] exp_rd(input int p);
        return 8'h3C ^ 8'(p * 29);
    endfunction

    assign rd_data = exp_rd(rd_ptr);

    spd_i2c_front uut (
        .clk (clk), .rst (rst), .scl_in (scl), .sda_in (sda_line),
        .strap_addr (strap_addr), .prot_locked (prot_locked),
        .wr_busy (wr_busy), .wr_nack (wr_nack), .rd_data (rd_data),
        .sda_pull (sda_pull), .bus_start (bus_start), .bus_stop (bus_stop),
        .sel_valid (sel_valid), .sel_target (sel_target), .sel_read (sel_read),
        .byte_valid (byte_valid), .byte_data (byte_data), .rd_take (rd_take),
        .rd_done (rd_done), .rd_master_ack (rd_master_ack)
    );

    always @(posedge clk) begin
        if (!rst) begin
            if (bus_start)  start_cnt++;
            if (bus_stop)   stop_cnt++;
            if (sel_valid)  sel_cnt++;
            if (byte_valid) byte_cnt++;
            if (rd_done)    done_cnt++;
            if (rd_take) begin
                take_cnt++;
                rd_ptr++;
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic i2c_start();
        scl = 1'b0; tick(4);
        m_sda = 1'b1; tick(4);
        scl = 1'b1; tick(8);
        m_sda = 1'b0; tick(8);
        scl = 1'b0;
    endtask

    task automatic i2c_stop();
        scl = 1'b0; tick(4);
        m_sda = 1'b0; tick(4);
        scl = 1'b1; tick(8);
        m_sda = 1'b1; tick(8);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            scl = 1'b0; tick(4);
            m_sda = b[i]; tick(4);
            scl = 1'b1; tick(8);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        send_bits(b, 8);
        scl = 1'b0; tick(4);
        m_sda = 1'b1; tick(4);
        scl = 1'b1; tick(4);
        acked = ~sda_line;
        tick(4);
        scl = 1'b0;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] d);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            scl = 1'b0; tick(8);
            scl = 1'b1; tick(4);
            d[i] = sda_line;
            tick(4);
        end
        scl = 1'b0; tick(4);
        m_sda = give_ack ? 1'b0 : 1'b1; tick(4);
        scl = 1'b1; tick(8);
        scl = 1'b0; tick(4);
        m_sda = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        bit         ack;
        logic [7:0] d;
        int         s0, b0;

        tick(6);
        rst = 1'b0;
        tick(4);
        check(sda_pull == 1'b0, "R1", "reset pull", sda_pull, 0);
        check(sel_cnt == 0 && byte_cnt == 0, "R1", "reset strobes", sel_cnt + byte_cnt, 0);

        // R1 start/stop detection
        s0 = start_cnt;
        i2c_start();
        check(start_cnt == s0 + 1, "R1", "start pulses", start_cnt, s0 + 1);
        s0 = stop_cnt;
        i2c_stop();
        check(stop_cnt == s0 + 1, "R1", "stop pulses", stop_cnt, s0 + 1);

        // R2 / R5 chip-address sweep with the array identifier
        for (int s = 0; s < 8; s++) begin
            for (int a = 0; a < 8; a++) begin
                strap_addr = 3'(s);
                s0 = sel_cnt;
                i2c_start();
                send_byte({4'b1010, 3'(a), 1'b0}, ack);
                i2c_stop();
                check(ack == (a == s), (a == s) ? "R2" : "R5", "addr ack", ack, a == s);
                check((sel_cnt - s0) == ((a == s) ? 1 : 0), "R2", "sel strobe",
                      sel_cnt - s0, a == s);
                if (a == s)
                    check(sel_target == 1'b0, "R2", "target array", sel_target, 0);
            end
        end

        // R3 / R5 identifier sweep, unlocked
        strap_addr = 3'd5;
        for (int id = 0; id < 16; id++) begin
            bit exp_ack;
            exp_ack = (id == 4'b1010) || (id == 4'b0110);
            i2c_start();
            send_byte({4'(id), 3'd5, 1'b0}, ack);
            i2c_stop();
            check(ack == exp_ack, (id == 6) ? "R3" : "R5", "id ack", ack, exp_ack);
            if (id == 6)
                check(sel_target == 1'b1, "R3", "target reg", sel_target, 1);
        end

        // R6 write bytes
        i2c_start();
        send_byte({4'b1010, 3'd5, 1'b0}, ack);
        check(ack && sel_read == 1'b0, "R6", "write select", ack, 1);
        foreach (d[i]) ; // no-op
        for (int k = 0; k < 3; k++) begin
            logic [7:0] v;
            v = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'h96;
            b0 = byte_cnt;
            send_byte(v, ack);
            check(ack == 1'b1, "R6", "data ack", ack, 1);
            check(byte_data == v, "R6", "byte data", byte_data, v);
            check(byte_cnt == b0 + 1, "R6", "byte strobe", byte_cnt, b0 + 1);
        end

        // R7 refused byte
        wr_nack = 1'b1;
        b0 = byte_cnt;
        send_byte(8'h5A, ack);
        wr_nack = 1'b0;
        check(ack == 1'b0, "R7", "refused ack", ack, 0);
        check(byte_data == 8'h5A && byte_cnt == b0 + 1, "R7", "refused data", byte_data, 8'h5A);
        i2c_stop();

        // R5 bytes after a mismatch are ignored
        b0 = byte_cnt;
        i2c_start();
        send_byte({4'b1010, 3'd2, 1'b0}, ack);
        check(ack == 1'b0, "R5", "mismatch select", ack, 0);
        send_byte(8'h11, ack);
        check(ack == 1'b0, "R5", "ignored byte ack", ack, 0);
        check(byte_cnt == b0, "R5", "ignored byte strobe", byte_cnt, b0);
        i2c_stop();

        // R8 sequential read
        rd_ptr = 0;
        i2c_start();
        send_byte({4'b1010, 3'd5, 1'b1}, ack);
        check(ack == 1'b1 && sel_read == 1'b1, "R8", "read select", ack, 1);
        for (int k = 0; k < 4; k++) begin
            recv_byte(k != 3, d);
            check(d == exp_rd(k), "R8", "read data", d, exp_rd(k));
        end
        check(done_cnt > 0 && rd_master_ack == 1'b0, "R8", "final noack seen", rd_master_ack, 0);
        check(take_cnt == 4, "R8", "bytes loaded", take_cnt, 4);
        recv_byte(1'b0, d);
        check(d == 8'hFF, "R8", "standby after noack", d, 8'hFF);
        i2c_stop();

        // R4 lock
        prot_locked = 1'b1;
        s0 = sel_cnt;
        i2c_start();
        send_byte({4'b0110, 3'd5, 1'b0}, ack);
        i2c_stop();
        check(ack == 1'b0 && sel_cnt == s0, "R4", "locked reg select", ack, 0);
        i2c_start();
        send_byte({4'b0110, 3'd5, 1'b1}, ack);
        i2c_stop();
        check(ack == 1'b0, "R4", "locked reg read select", ack, 0);
        i2c_start();
        send_byte({4'b1010, 3'd5, 1'b0}, ack);
        i2c_stop();
        check(ack == 1'b1, "R4", "array still answered", ack, 1);
        prot_locked = 1'b0;

        // R9 busy
        wr_busy = 1'b1;
        s0 = start_cnt;
        b0 = sel_cnt;
        i2c_start();
        send_byte({4'b1010, 3'd5, 1'b0}, ack);
        i2c_stop();
        check(ack == 1'b0, "R9", "busy ack", ack, 0);
        check(start_cnt == s0 && sel_cnt == b0, "R9", "busy strobes", start_cnt - s0, 0);
        wr_busy = 1'b0;
        tick(4);

        // R10 start mid-byte
        s0 = sel_cnt;
        b0 = byte_cnt;
        i2c_start();
        send_bits(8'hF0, 4);
        i2c_start();
        send_byte({4'b1010, 3'd5, 1'b0}, ack);
        check(ack == 1'b1, "R10", "restart select ack", ack, 1);
        check(sel_cnt == s0 + 1 && byte_cnt == b0, "R10", "restart strobes", sel_cnt - s0, 1);
        i2c_stop();

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule